// File: doc/BRIEF.md
# Synthesizer Channel Bring-Up Sequencer

This block brings one channel of a direct digital synthesizer out of reset and through its DAC calibration with no software in the loop. It masters a 16-bit parallel register bus that has an address, write data, a write strobe and a ready input. A start pulse carries a channel number. The block then plays a fixed script of nine register writes. It selects the channel and pulses the chip reset through a GPIO register. It loads the configuration words with calibration enabled and commits them with a frequency-update write. It waits a long, parameterised time for the calibration to settle. Finally it clears the calibration enable, commits again, and reports completion.

Each register write takes a fixed slot of bus cycles. The channel-select field can use a binary or a one-hot encoding, chosen when the block is built. The calibration wait is given in clock cycles, so a system clock of any rate can cover the settling time with margin.

Top module: `dds_cal_sequencer`

## Requirements
- R1: Out of reset, `busy`, `done` and `bus_we` are all low, and `bus_we` stays low whenever `busy` is low.
- R2: A `start` pulse is taken only while the block is idle, and `busy` rises on the next cycle. A `start` that arrives while busy is ignored: the running script keeps the channel it latched, only one `done` is produced, and no write follows that `done`.
- R3: The script opens with three writes to GPIO address 0x81 with data S, then S|1, then S. Bit 0 is the reset line, and the select value S sits from bit 1 upward.
- R4: With `SEL_ONEHOT`=0, S = channel << 1. With `SEL_ONEHOT`=1, S = (1 << channel) << 1.
- R5: Next come writes of 0x0008 to address 0x01, 0x0000 to address 0x03 and 0x0105 to address 0x0f, and then a write of 0x0000 to the update address 0x80.
- R6: After the slot of that first update write, the strobe of the next write is delayed by a further `CAL_CYC` cycles.
- R7: The script closes with 0x0005 written to address 0x0f and then 0x0000 written to address 0x80.
- R8: A write is accepted on a cycle where `bus_we` and `bus_rdy` are both high. `bus_we` is low on the cycle after an acceptance, and the next write's strobe first appears `SLOT_CYC` cycles after the acceptance cycle.
- R9: While `bus_we` is high and `bus_rdy` is low, the strobe, address and data hold unchanged.
- R10: `done` is high for exactly one cycle, `SLOT_CYC` cycles after the last write is accepted. On that cycle `busy` is already low, and `busy` never falls without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken while idle |
| chan | input | CH_W | Channel number latched at start |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Register write data |
| bus_we | output | 1 | Write strobe, held until ready |
| bus_rdy | input | 1 | Bus ready; accepts the write when high with the strobe |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the bus handshake on every cycle. It checks that the strobe is silent while idle, that address and data hold through a stall, and that the strobe drops after each acceptance. It also checks the shape of `done` against `busy` and that a start is taken from idle. The write order, the address and data values for both select encodings, the exact slot spacing, the calibration delay and the case of a start that arrives mid-script are shown only by the bench. It runs directed and random channels, random ready stalls and intruding start pulses on a binary instance and a one-hot instance side by side.

// File: rtl/dds_cal_sequencer.sv
module dds_cal_sequencer #(
  parameter int N_CH       = 8,
  parameter bit SEL_ONEHOT = 1'b0,
  parameter int SLOT_CYC   = 5,
  parameter int CAL_CYC    = 30000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  input  logic              bus_rdy,
  output logic              busy,
  output logic              done
);

  localparam int CMAX  = (SLOT_CYC > CAL_CYC) ? SLOT_CYC : CAL_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [3:0] LAST_STEP = 4'd8;
  localparam logic [3:0] CAL_STEP  = 4'd6;

  localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(8'h03);
  localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(8'h0f);
  localparam logic [ADDR_W-1:0] A_UPD    = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] A_GPIO   = ADDR_W'(8'h81);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_GAP, S_CAL} st_t;

  st_t              st;
  logic [3:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  ch_q;
  logic [DATA_W-1:0] sel;

  generate
    if (SEL_ONEHOT) begin : g_onehot
      assign sel = (DATA_W'(1) << ch_q) << 1;
    end else begin : g_binary
      assign sel = DATA_W'(ch_q) << 1;
    end
  endgenerate

  assign bus_we = (st == S_WR);
  assign busy   = (st != S_IDLE);

  always_comb begin
    bus_addr  = A_UPD;
    bus_wdata = '0;
    case (step)
      4'd0, 4'd2: begin bus_addr = A_GPIO;   bus_wdata = sel; end
      4'd1:       begin bus_addr = A_GPIO;   bus_wdata = sel | DATA_W'(1); end
      4'd3:       begin bus_addr = A_CFG_LO; bus_wdata = DATA_W'(16'h0008); end
      4'd4:       begin bus_addr = A_CFG_HI; bus_wdata = '0; end
      4'd5:       begin bus_addr = A_CAL;    bus_wdata = DATA_W'(16'h0105); end
      4'd7:       begin bus_addr = A_CAL;    bus_wdata = DATA_W'(16'h0005); end
      default:    begin bus_addr = A_UPD;    bus_wdata = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      step <= '0;
      cnt  <= '0;
      ch_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ch_q <= chan;
          step <= '0;
          st   <= S_WR;
        end
        S_WR: if (bus_rdy) begin
          cnt <= '0;
          st  <= S_GAP;
        end
        S_GAP: if (cnt == CNT_W'(SLOT_CYC - 2)) begin
          cnt <= '0;
          if (step == LAST_STEP) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            step <= step + 4'd1;
            st   <= (step == CAL_STEP) ? S_CAL : S_WR;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        S_CAL: if (cnt == CNT_W'(CAL_CYC - 1)) begin
          cnt <= '0;
          st  <= S_WR;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dds_cal_sequencer_chk.sv
module dds_cal_sequencer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_rdy,
  input logic              busy,
  input logic              done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_we);

  p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_gap_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_rdy) |=> !bus_we);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_rdy) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind dds_cal_sequencer dds_cal_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdy(bus_rdy),
  .busy(busy), .done(done)
);

// File: tb/sim_dds_cal_sequencer.sv
module sim_dds_cal_sequencer;
  localparam int N_CH = 8;
  localparam int CH_W = 3;
  localparam int SLOT = 5;
  localparam int CAL  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CH_W-1:0] chan = '0;
  logic rdy = 1'b1;
  logic [7:0]  addr [2];
  logic [15:0] wdata [2];
  logic we [2], busy [2], done [2];

  int cyc = 0, n_chk = 0, n_bad = 0;
  int run_ch = 0;
  bit stall_en = 1'b0;
  bit wd_hit = 1'b0;
  int step [2] = '{0, 0};
  int last_acc [2] = '{0, 0};
  bit prev_we [2] = '{0, 0};
  int done_cnt [2] = '{0, 0};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rdy <= stall_en ? (($urandom % 3) != 0) : 1'b1;

  dds_cal_sequencer #(.N_CH(N_CH), .SEL_ONEHOT(1'b0), .SLOT_CYC(SLOT), .CAL_CYC(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .bus_addr(addr[0]),
    .bus_wdata(wdata[0]), .bus_we(we[0]), .bus_rdy(rdy), .busy(busy[0]), .done(done[0]));

  dds_cal_sequencer #(.N_CH(N_CH), .SEL_ONEHOT(1'b1), .SLOT_CYC(SLOT), .CAL_CYC(CAL)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .bus_addr(addr[1]),
    .bus_wdata(wdata[1]), .bus_we(we[1]), .bus_rdy(rdy), .busy(busy[1]), .done(done[1]));

  function automatic int sel_val(int ch, bit oh);
    return oh ? ((1 << ch) << 1) : (ch << 1);
  endfunction

  function automatic int exp_addr(int s);
    case (s)
      0, 1, 2: return 'h81;
      3: return 'h01;
      4: return 'h03;
      5, 7: return 'h0f;
      default: return 'h80;
    endcase
  endfunction

  function automatic int exp_data(int s, int ch, bit oh);
    case (s)
      0, 2: return sel_val(ch, oh);
      1: return sel_val(ch, oh) | 1;
      3: return 'h0008;
      5: return 'h0105;
      7: return 'h0005;
      default: return 0;
    endcase
  endfunction

  function automatic string step_tag(int s);
    if (s <= 2) return "R3/R4";
    if (s <= 6) return "R5";
    return "R7";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      for (int i = 0; i < 2; i++) begin
        if (we[i]) begin
          if (!prev_we[i] && step[i] != 0) begin
            if (step[i] == 7)
              chk(cyc - last_acc[i] == SLOT + CAL, "R6 calibration delay", cyc - last_acc[i], SLOT + CAL);
            else
              chk(cyc - last_acc[i] == SLOT, "R8 slot spacing", cyc - last_acc[i], SLOT);
          end
          chk(step[i] <= 8, "R10 no write past script", step[i], 8);
          chk(int'(addr[i]) == exp_addr(step[i]),
              rdy ? step_tag(step[i]) : "R9 address held in stall", addr[i], exp_addr(step[i]));
          chk(int'(wdata[i]) == exp_data(step[i], run_ch, i[0]),
              rdy ? step_tag(step[i]) : "R9 data held in stall", wdata[i], exp_data(step[i], run_ch, i[0]));
          if (rdy) begin
            last_acc[i] = cyc;
            step[i]++;
          end
        end
        prev_we[i] = we[i];
        if (done[i]) begin
          chk(step[i] == 9, "R10 done after full script", step[i], 9);
          chk(cyc - last_acc[i] == SLOT, "R10 done timing", cyc - last_acc[i], SLOT);
          chk(!busy[i], "R10 busy low with done", busy[i], 0);
          done_cnt[i]++;
          step[i] = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(!busy[i], "R1 busy in reset", busy[i], 0);
      chk(!done[i], "R1 done in reset", done[i], 0);
      chk(!we[i], "R1 strobe in reset", we[i], 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(!busy[i] && !we[i], "R1 idle after reset", busy[i], 0);

    for (int run = 0; run < 12; run++) begin
      int ch;
      bit intrude;
      ch = (run == 0) ? 0 : (run == 1) ? N_CH - 1 : int'($urandom % N_CH);
      intrude = (run % 2) == 1;
      run_ch = ch;
      stall_en = (run >= 3) && (($urandom % 2) == 1);
      @(posedge clk);
      start <= 1'b1;
      chan <= CH_W'(ch);
      @(posedge clk);
      start <= 1'b0;
      chan <= CH_W'($urandom % N_CH);
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        chk(busy[i], "R2 start taken from idle", busy[i], 1);
      if (intrude) begin
        repeat (18) @(posedge clk);
        start <= 1'b1;
        chan <= CH_W'((ch + 1) % N_CH);
        @(posedge clk);
        start <= 1'b0;
      end
      while (!(done_cnt[0] == run + 1 && done_cnt[1] == run + 1)) @(negedge clk);
      stall_en = 1'b0;
      repeat (3 * SLOT) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk(!busy[i], "R2 start while busy ignored", busy[i], 0);
        chk(done_cnt[i] == run + 1, "R2 one done per script", done_cnt[i], run + 1);
      end
    end
    summary();
  end
endmodule